// File: doc/BRIEF.md
# Transmission Parameter Signalling Frame Synchronizer and Parser

This block takes a stream of received signalling bits, one per OFDM symbol, that earlier logic has already recovered from the pilot carriers. A one-cycle strobe marks each bit. The block removes the differential (2-DPSK) modulation and hunts for a 16-bit synchronization word. Successive frames carry this word in alternating polarity. Once framing is confirmed, the block slices each frame's parameter fields into registers that the host can see. It also reports lock and validity.

The block is built around a four-state framing machine:
- `ST_HUNT` searches for the word in either polarity, bit by bit.
- `ST_CONFIRM` waits one frame for the word in the opposite polarity.
- `ST_LOCKED` is normal tracking.
- `ST_FLYWHEEL` rides over a single missed word.

The transitions are:
- HUNT→CONFIRM on a match in either polarity.
- CONFIRM→LOCKED on an expected-polarity match.
- CONFIRM→HUNT on a miss.
- LOCKED→FLYWHEEL on a miss.
- FLYWHEEL→LOCKED on a match.
- FLYWHEEL→HUNT on a second miss in a row.

Software reaches the fields through a small index register. Writing the index register with the release bit clear freezes the parameter registers, so that the values read back form one consistent snapshot. Writing it with the release bit set lets updating resume. The lock flags for timing and frequency come from other blocks. They are only forwarded into the status word.

Top module: `tps_sync_parser`

## Requirements
- R1: Each decoded bit is `sym_bit` XOR the raw bit of the previous strobed symbol; after reset that previous raw bit is 0. A stream whose raw bits carry the sync pattern without differential encoding never produces lock.
- R2: In ST_HUNT, when the last 16 decoded bits, earliest on the left, equal 0011010111101110 or 1100101000010001, the machine enters ST_CONFIRM. The polarity found is the one expected for that frame, and the next bit is taken as s17.
- R3: A frame is 68 bits (s0..s67). The expected polarity flips at every frame boundary, and the sync check happens on bit s16 of each frame.
- R4: In ST_CONFIRM, a word of the expected polarity at s16 moves the machine to ST_LOCKED, and `tps_lock` rises one cycle after that bit's strobe. A mismatch returns the machine to ST_HUNT. `tps_lock` is high exactly in ST_LOCKED and ST_FLYWHEEL.
- R5: In ST_LOCKED, a miss moves to ST_FLYWHEEL and lock is kept. In ST_FLYWHEEL, a hit returns to ST_LOCKED and a miss drops to ST_HUNT with `tps_lock` low.
- R6: While locked, bits s17..s39 are sliced MSB first into these fields:
  - length s17..s22
  - frame number s23..s24
  - constellation s25..s26
  - hierarchy s27..s29
  - high-priority rate s30..s32
  - low-priority rate s33..s35
  - guard s36..s37
  - mode s38..s39

  At s39, if the length field is 010111, `tps_valid` is set and the parameter registers load; otherwise `tps_valid` clears and the registers hold. Leaving lock clears `tps_valid`.
- R7: A write (`idx_wr`) with `idx_wdata[7]`=0 freezes the parameter registers. Frames decoded afterwards do not change what is read.
- R8: A write with `idx_wdata[7]`=1 releases the freeze. Values change only at the next good frame, never retroactively.
- R9: `idx_wdata[3:0]` selects the register that `rd_data` shows, zero-extended:
  - 0 frame number
  - 1 constellation
  - 2 hierarchy
  - 3 high-priority rate
  - 4 low-priority rate
  - 5 guard
  - 6 mode
  - 7 status, with bit 3 lock, bit 2 valid, bit 1 `timing_lock`, bit 0 `afc_lock`

  Any other index reads 0.
- R10: After reset, lock and valid are 0, all parameter registers are 0, the block is not frozen and the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Strobe: `sym_bit` holds a new received bit |
| sym_bit | input | 1 | Raw differentially modulated signalling bit |
| timing_lock | input | 1 | Timing synchronisation lock from outside |
| afc_lock | input | 1 | Frequency control lock from outside |
| idx_wr | input | 1 | Index register write strobe |
| idx_wdata | input | 8 | Bit 7 release, bits 3:0 register index |
| rd_data | output | 8 | Selected register, zero-extended |
| tps_lock | output | 1 | Frame lock (LOCKED or FLYWHEEL) |
| tps_valid | output | 1 | Last locked frame had a good length field |

## Verification
Every result is due one clock after the edge that samples the causing strobe:
- `tps_lock` after the s16 bit.
- `tps_valid` and the parameter registers after the s39 bit.
- `rd_data` after an index write.

The bench changes inputs on falling edges. A behavioural model advances on each rising edge, and the lock, valid and read outputs are compared with it on the following falling edge, so every comparison falls exactly one register stage behind its cause. The scenario checks are taken only after a whole frame or a write task has completed, which is well past those points.

// File: rtl/tps_pkg.sv
package tps_pkg;
    localparam int FRAME_LEN   = 68;
    localparam int SYNC_LEN    = 16;
    localparam int SYNC_END    = 16;
    localparam int FIELD_FIRST = 17;
    localparam int FIELD_LAST  = 39;
    localparam int FIELD_BITS  = FIELD_LAST - FIELD_FIRST + 1;
    localparam int LEN_W       = 6;
    localparam int POS_W       = $clog2(FRAME_LEN);
    localparam logic [SYNC_LEN-1:0] SYNC_WORD = 16'b0011010111101110;
    localparam logic [LEN_W-1:0]    LEN_GOOD  = 6'b010111;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_CONFIRM,
        ST_LOCKED,
        ST_FLYWHEEL
    } sync_state_t;

    // Field order matches transmission order so a slice of the frame maps directly.
    typedef struct packed {
        logic [1:0] frame_no;
        logic [1:0] constel;
        logic [2:0] hier;
        logic [2:0] rate_hp;
        logic [2:0] rate_lp;
        logic [1:0] guard;
        logic [1:0] mode;
    } tps_params_t;

    localparam int PARAM_BITS = $bits(tps_params_t);
endpackage

// File: rtl/tps_diff_decoder.sv
module tps_diff_decoder (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_valid,
    input  logic sym_bit,
    output logic dec_bit
);
    logic prev_raw;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_raw <= 1'b0;
        end else if (sym_valid) begin
            prev_raw <= sym_bit;
        end
    end

    // Phase change between adjacent symbols carries the information.
    assign dec_bit = sym_bit ^ prev_raw;
endmodule

// File: rtl/tps_frame_sync.sv
module tps_frame_sync
    import tps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             bit_val,
    output logic             locked,
    output logic             to_hunt,
    output logic [POS_W-1:0] pos
);
    sync_state_t         st_q, st_d;
    logic [SYNC_LEN-1:0] win_q, win_d;
    logic [POS_W-1:0]    pos_q;
    logic                pol_q;
    logic                hit_norm, hit_inv, hit_exp, at_check, at_wrap;

    assign win_d    = {win_q[SYNC_LEN-2:0], bit_val};
    assign hit_norm = (win_d == SYNC_WORD);
    assign hit_inv  = (win_d == ~SYNC_WORD);
    assign hit_exp  = pol_q ? hit_inv : hit_norm;
    assign at_check = (pos_q == POS_W'(SYNC_END));
    assign at_wrap  = (pos_q == POS_W'(FRAME_LEN - 1));

    always_comb begin
        st_d = st_q;
        if (bit_stb) begin
            unique case (st_q)
                ST_HUNT:     if (hit_norm || hit_inv) st_d = ST_CONFIRM;
                ST_CONFIRM:  if (at_check) st_d = hit_exp ? ST_LOCKED : ST_HUNT;
                ST_LOCKED:   if (at_check && !hit_exp) st_d = ST_FLYWHEEL;
                ST_FLYWHEEL: if (at_check) st_d = hit_exp ? ST_LOCKED : ST_HUNT;
                default:     st_d = ST_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_HUNT;
        else        st_q <= st_d;
    end

    // Window, bit position and expected polarity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
            pos_q <= '0;
            pol_q <= 1'b0;
        end else if (bit_stb) begin
            win_q <= win_d;
            if (st_q == ST_HUNT) begin
                if (hit_norm || hit_inv) begin
                    pos_q <= POS_W'(SYNC_END + 1);
                    pol_q <= hit_inv;
                end
            end else if (st_d == ST_HUNT) begin
                pos_q <= '0;
                pol_q <= 1'b0;
            end else begin
                pos_q <= at_wrap ? '0 : pos_q + POS_W'(1);
                if (at_wrap) pol_q <= ~pol_q;
            end
        end
    end

    assign locked  = (st_q == ST_LOCKED) || (st_q == ST_FLYWHEEL);
    assign to_hunt = (st_q != ST_HUNT) && (st_d == ST_HUNT);
    assign pos     = pos_q;

    AST_LOCK_VIA_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(st_q) == ST_CONFIRM); // R4
    AST_DROP_AFTER_FLYWHEEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(st_q) == ST_FLYWHEEL); // R5
    AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q < POS_W'(FRAME_LEN)); // R3
    AST_POL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && at_wrap && st_q != ST_HUNT) |=> pol_q != $past(pol_q)); // R3
endmodule

// File: rtl/tps_field_capture.sv
module tps_field_capture
    import tps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             bit_val,
    input  logic             locked,
    input  logic             to_hunt,
    input  logic [POS_W-1:0] pos,
    input  logic             freeze,
    output tps_params_t      params,
    output logic             frame_ok
);
    logic [FIELD_BITS-2:0] sh_q;
    logic [FIELD_BITS-1:0] full;
    logic                  in_field, at_last, len_ok, take;

    assign full     = {sh_q, bit_val};
    assign in_field = (pos >= POS_W'(FIELD_FIRST)) && (pos <= POS_W'(FIELD_LAST));
    assign at_last  = (pos == POS_W'(FIELD_LAST));
    assign len_ok   = (full[FIELD_BITS-1 -: LEN_W] == LEN_GOOD);
    assign take     = bit_stb && locked && at_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            frame_ok <= 1'b0;
            params   <= '0;
        end else begin
            if (bit_stb && locked && in_field) sh_q <= full[FIELD_BITS-2:0];
            if (to_hunt)   frame_ok <= 1'b0;
            else if (take) frame_ok <= len_ok;
            if (take && len_ok && !freeze) params <= tps_params_t'(full[PARAM_BITS-1:0]);
        end
    end

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(freeze) |-> $stable(params)); // R7
    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> locked); // R6
endmodule

// File: rtl/tps_host_if.sv
module tps_host_if
    import tps_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4,
    parameter int STAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic [DATA_W-1:0] idx_wdata,
    input  tps_params_t       params,
    input  logic [STAT_W-1:0] status,
    output logic              freeze,
    output logic [DATA_W-1:0] rd_data
);
    localparam int REL_BIT = DATA_W - 1;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            freeze <= 1'b0;
        end else if (idx_wr) begin
            idx_q  <= idx_wdata[IDX_W-1:0];
            freeze <= ~idx_wdata[REL_BIT];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (idx_q)
            IDX_W'(0): rd_data[1:0]        = params.frame_no;
            IDX_W'(1): rd_data[1:0]        = params.constel;
            IDX_W'(2): rd_data[2:0]        = params.hier;
            IDX_W'(3): rd_data[2:0]        = params.rate_hp;
            IDX_W'(4): rd_data[2:0]        = params.rate_lp;
            IDX_W'(5): rd_data[1:0]        = params.guard;
            IDX_W'(6): rd_data[1:0]        = params.mode;
            IDX_W'(7): rd_data[STAT_W-1:0] = status;
            default:   rd_data             = '0;
        endcase
    end

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && idx_wdata[REL_BIT]) |=> !freeze); // R8
    AST_WRITE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && !idx_wdata[REL_BIT]) |=> freeze); // R7
endmodule

// File: rtl/tps_sync_parser.sv
module tps_sync_parser
    import tps_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_valid,
    input  logic              sym_bit,
    input  logic              timing_lock,
    input  logic              afc_lock,
    input  logic              idx_wr,
    input  logic [DATA_W-1:0] idx_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              tps_lock,
    output logic              tps_valid
);
    localparam int STAT_W = 4;

    logic             dec_bit, locked, to_hunt, freeze, frame_ok;
    logic [POS_W-1:0] pos;
    tps_params_t      params;
    logic [STAT_W-1:0] status;

    tps_diff_decoder u_dec (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_bit(sym_bit), .dec_bit(dec_bit)
    );

    tps_frame_sync u_sync (
        .clk(clk), .rst_n(rst_n), .bit_stb(sym_valid), .bit_val(dec_bit),
        .locked(locked), .to_hunt(to_hunt), .pos(pos)
    );

    tps_field_capture u_cap (
        .clk(clk), .rst_n(rst_n), .bit_stb(sym_valid), .bit_val(dec_bit),
        .locked(locked), .to_hunt(to_hunt), .pos(pos), .freeze(freeze),
        .params(params), .frame_ok(frame_ok)
    );

    assign status = {locked, frame_ok, timing_lock, afc_lock};

    tps_host_if #(.DATA_W(DATA_W), .IDX_W(IDX_W), .STAT_W(STAT_W)) u_host (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
        .params(params), .status(status), .freeze(freeze), .rd_data(rd_data)
    );

    assign tps_lock  = locked;
    assign tps_valid = frame_ok;

    AST_STATUS_OUT_OF_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> (!tps_lock && !tps_valid)); // R10
endmodule

// File: tb/tps_sync_parser_tb.sv
module tps_sync_parser_tb;
    localparam bit [15:0] SW = 16'b0011010111101110;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0, sym_bit = 1'b0;
    logic       timing_lock = 1'b0, afc_lock = 1'b0;
    logic       idx_wr = 1'b0;
    logic [7:0] idx_wdata = 8'h00;
    logic [7:0] rd_data;
    logic       tps_lock, tps_valid;

    int vectors = 0;
    int errs = 0;
    bit done = 0;
    bit tx_prev = 0;

    always #10 clk = ~clk;

    tps_sync_parser u_dut (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_bit(sym_bit),
        .timing_lock(timing_lock), .afc_lock(afc_lock), .idx_wr(idx_wr),
        .idx_wdata(idx_wdata), .rd_data(rd_data), .tps_lock(tps_lock), .tps_valid(tps_valid)
    );

    // ---------------- behavioural reference model ----------------
    int        m_st;     // 0 hunt, 1 confirm, 2 locked, 3 flywheel
    int        m_pos;
    bit        m_pol, m_prev, m_valid, m_frz;
    bit [15:0] m_win;
    bit        m_fields[$];
    int        m_idx;
    int        m_par[7];

    function automatic int fld(int s, int n);
        int v = 0;
        for (int i = 0; i < n; i++) v = (v << 1) | int'(m_fields[s - 17 + i]);
        return v;
    endfunction

    function automatic int m_rd();
        if (m_idx <= 6) return m_par[m_idx];
        if (m_idx == 7) return {28'd0, m_st >= 2, m_valid, timing_lock, afc_lock};
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pos = 0; m_pol = 0; m_prev = 0; m_valid = 0; m_frz = 0;
            m_win = 0; m_idx = 0; m_fields.delete();
            for (int i = 0; i < 7; i++) m_par[i] = 0;
        end else begin
            if (sym_valid) begin
                bit d, hit, was_locked;
                int cur;
                d = sym_bit ^ m_prev;
                m_prev = sym_bit;
                m_win = {m_win[14:0], d};
                was_locked = (m_st >= 2);
                if (m_st == 0) begin
                    if (m_win == SW || m_win == ~SW) begin
                        m_st = 1; m_pol = (m_win != SW); m_pos = 17; m_fields.delete();
                    end
                end else begin
                    cur = m_pos;
                    hit = (m_win == (m_pol ? ~SW : SW));
                    if (cur == 16) begin
                        if (m_st == 1)      m_st = hit ? 2 : 0;
                        else if (m_st == 2) m_st = hit ? 2 : 3;
                        else                m_st = hit ? 2 : 0;
                    end
                    if (was_locked && cur >= 17 && cur <= 39) m_fields.push_back(d);
                    if (was_locked && cur == 39) begin
                        m_valid = (fld(17, 6) == 6'b010111);
                        if (m_valid && !m_frz) begin
                            m_par[0] = fld(23, 2); m_par[1] = fld(25, 2); m_par[2] = fld(27, 3);
                            m_par[3] = fld(30, 3); m_par[4] = fld(33, 3); m_par[5] = fld(36, 2);
                            m_par[6] = fld(38, 2);
                        end
                        m_fields.delete();
                    end
                    if (m_st == 0) begin
                        m_pos = 0; m_pol = 0; m_valid = 0; m_fields.delete();
                    end else begin
                        m_pos = (cur == 67) ? 0 : cur + 1;
                        if (cur == 67) m_pol = !m_pol;
                    end
                end
            end
            if (idx_wr) begin
                m_idx = int'(idx_wdata[3:0]);
                m_frz = !idx_wdata[7];
            end
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (tps_lock !== (m_st >= 2)) begin
                errs++; $display("FAIL R4 lock: got %0b exp %0b", tps_lock, m_st >= 2);
            end
            vectors++;
            if (tps_valid !== m_valid) begin
                errs++; $display("FAIL R6 valid: got %0b exp %0b", tps_valid, m_valid);
            end
            vectors++;
            if (int'(rd_data) != m_rd()) begin
                errs++; $display("FAIL R9 rd_data: got %0d exp %0d", rd_data, m_rd());
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(string req, int got, int exp);
        vectors++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s: got %0d exp %0d", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_raw(bit b);
        @(negedge clk); sym_valid = 1'b1; sym_bit = b;
        @(negedge clk); sym_valid = 1'b0;
    endtask

    task automatic send_info(bit b, bit diff);
        if (diff) begin
            tx_prev = tx_prev ^ b;
            send_raw(tx_prev);
        end else begin
            send_raw(b);
        end
    endtask

    task automatic put(ref bit q[$], input int v, input int n);
        for (int i = n - 1; i >= 0; i--) q.push_back(v[i]);
    endtask

    task automatic send_frame(bit inv, int len, int fno, int con, int hie, int hp, int lp,
                              int gi, int md, bit diff);
        bit q[$];
        q.push_back(1'b0);
        put(q, int'(inv ? ~SW : SW), 16);
        put(q, len, 6); put(q, fno, 2); put(q, con, 2); put(q, hie, 3);
        put(q, hp, 3); put(q, lp, 3); put(q, gi, 2); put(q, md, 2);
        put(q, 0, 28);
        foreach (q[i]) send_info(q[i], diff);
    endtask

    task automatic host_write(logic [7:0] d);
        @(negedge clk); idx_wr = 1'b1; idx_wdata = d;
        @(negedge clk); idx_wr = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++;
            $display("FAIL watchdog: got timeout exp completion");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: reset state
        check("R10 lock", tps_lock, 0);
        check("R10 valid", tps_valid, 0);
        check("R10 rd", rd_data, 0);

        // R1: sync pattern sent without differential encoding must not lock
        send_frame(0, 6'b010111, 0, 1, 0, 1, 0, 1, 0, 0);
        send_frame(1, 6'b010111, 1, 1, 0, 1, 0, 1, 0, 0);
        check("R1 no lock on undecoded pattern", tps_lock, 0);

        do_reset();
        timing_lock = 1'b1; afc_lock = 1'b0;
        for (int i = 0; i < 20; i++) send_info(1'b0, 1);
        // R2/R4: first word only confirms
        send_frame(0, 6'b010111, 0, 2, 0, 2, 0, 3, 1, 1);
        check("R4 no lock after one word", tps_lock, 0);
        send_frame(1, 6'b010111, 1, 1, 3, 4, 1, 2, 0, 1);
        check("R4 lock after alternate word", tps_lock, 1);
        check("R6 valid", tps_valid, 1);
        host_write(8'h80); check("R9 frame_no", rd_data, 1);
        host_write(8'h81); check("R9 constel", rd_data, 1);
        host_write(8'h82); check("R6 hier", rd_data, 3);
        host_write(8'h83); check("R6 rate_hp", rd_data, 4);
        host_write(8'h84); check("R6 rate_lp", rd_data, 1);
        host_write(8'h85); check("R6 guard", rd_data, 2);
        host_write(8'h86); check("R6 mode", rd_data, 0);
        host_write(8'h87); check("R9 status", rd_data, 4'b1110);
        host_write(8'h89); check("R9 unused index", rd_data, 0);

        // R3: alternation continues
        send_frame(0, 6'b010111, 2, 0, 0, 0, 0, 0, 0, 1);
        host_write(8'h80); check("R3 frame_no tracks", rd_data, 2);
        check("R3 lock kept", tps_lock, 1);

        // R7: freeze
        host_write(8'h01);
        send_frame(1, 6'b010111, 3, 2, 1, 1, 1, 1, 1, 1);
        check("R7 frozen constel", rd_data, 0);
        host_write(8'h00); check("R7 frozen frame_no", rd_data, 2);

        // R8: release, no retroactive change, update next frame
        host_write(8'h81); check("R8 release holds", rd_data, 0);
        send_frame(0, 6'b010111, 0, 1, 0, 0, 0, 0, 0, 1);
        check("R8 update after release", rd_data, 1);

        // R6: bad length indicator
        send_frame(1, 6'b000000, 1, 3, 0, 0, 0, 0, 0, 1);
        check("R6 bad length clears valid", tps_valid, 0);
        check("R6 bad length holds params", rd_data, 1);

        // R5: single miss rides over, hit restores, two misses drop
        send_frame(1, 6'b010111, 2, 2, 0, 0, 0, 0, 0, 1);
        check("R5 lock after one miss", tps_lock, 1);
        send_frame(1, 6'b010111, 3, 2, 0, 0, 0, 0, 0, 1);
        check("R5 lock after recovery", tps_lock, 1);
        send_frame(1, 6'b010111, 0, 0, 0, 0, 0, 0, 0, 1);
        check("R5 lock after first miss", tps_lock, 1);
        send_frame(0, 6'b010111, 1, 0, 0, 0, 0, 0, 0, 1);
        check("R5 lock lost", tps_lock, 0);
        check("R6 valid cleared on loss", tps_valid, 0);

        // R2: hunt starting on the complemented word
        send_frame(1, 6'b010111, 1, 3, 0, 0, 0, 0, 0, 1);
        check("R2 inverted word confirms only", tps_lock, 0);
        send_frame(0, 6'b010111, 2, 2, 0, 0, 0, 0, 0, 1);
        check("R2 lock from inverted start", tps_lock, 1);
        check("R2 fields after relock", rd_data, 2);

        repeat (4) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule